// File: doc/BRIEF.md
# Paired-Register Read Slave for a Two-Wire Bus

This block is the serial front end of a 16-bit port device whose eight byte registers are arranged in pairs. It samples the bus clock and data lines with the system clock and finds START, repeated START and STOP conditions. It matches a 7-bit device address made of a fixed prefix and three strap pins. It acknowledges a command byte that sets a register pointer. When the master reads, the block shifts out bytes taken from a parallel register bank input. It drives the data line only through an open-drain pull-down enable.

A typical read has three parts. The master writes the address and a command byte, issues a repeated START, and then reads. The first byte returned is the register the command selected. Each further byte comes from the other register of the same pair, so the pointer swings between the two for as long as the master keeps acknowledging. A NACK from the master ends the read. A STOP returns the block to idle at any point.

Top module: `i2c_pair_slave`

## Requirements
- R1: The block acknowledges (pulls SDA low during the ninth clock) an address byte whose upper seven bits equal binary 0100 followed by strap_i[2:0]; bit 0 of that byte selects read (1) or write (0).
- R2: After an address byte that does not match, the block never asserts sda_oe_o until the next START.
- R3: In a write transfer the byte after the address is acknowledged, and its bits [2:0] become the register pointer; the pointer keeps its value across STOP and repeated START.
- R4: After a read address is acknowledged, the block sends register reg_data_i[8*p+7:8*p], where p is the pointer, most significant bit first.
- R5: Each byte the master acknowledges is followed by the byte of the register whose index differs only in bit 0, alternating with no limit.
- R6: After the master NACKs a byte, the block releases SDA and drives nothing until the next START.
- R7: A STOP (SDA rising while SCL is high) at any point releases SDA and aborts any partial byte; a partial command byte leaves the pointer unchanged.
- R8: A START or repeated START (SDA falling while SCL is high) aborts the current transfer and begins a new address byte.
- R9: A byte to send is captured from reg_data_i at the SCL falling edge that ends the preceding acknowledge clock; later changes to reg_data_i do not alter that byte.
- R10: sda_oe_o changes only while SCL is low.
- R11: In a write transfer, bytes after the command byte are not acknowledged and do not change the pointer.
- R12: After reset sda_oe_o is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line, asynchronous |
| sda_i | input | 1 | Bus data line as seen on the wire, asynchronous |
| strap_i | input | 3 | Low three address bits from strap pins |
| reg_data_i | input | 64 | Register bank, register k at bits [8k+7:8k] |
| sda_oe_o | output | 1 | Pull SDA low when high |

## Verification
Every cycle the assertions check that the data enable moves only while SCL is low, that START and STOP are followed by a released line, that the line stays released while the block is idle or ignoring a write, and that a pointer change made after a master acknowledge flips only bit 0. Only the bench scenarios can show the end-to-end results: the bytes and their order seen on the wire, the acknowledge or refusal of each address, command and extra data byte, the pointer surviving STOP and repeated START, and the moment at which the outgoing byte is captured from the register bank.

// File: rtl/i2cp_pkg.sv
package i2cp_pkg;

    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_ADDR = 3'd1,
        ST_AACK = 3'd2,
        ST_CMD  = 3'd3,
        ST_CACK = 3'd4,
        ST_WIGN = 3'd5,
        ST_TX   = 3'd6,
        ST_MACK = 3'd7
    } bus_state_t;

    localparam int BYTE_W = 8;

endpackage

// File: rtl/i2cp_sync.sv
module i2cp_sync #(
    parameter int WIDTH  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);

    logic [STAGES-1:0][WIDTH-1:0] chain_d, chain_q;

    always_comb begin
        chain_d[0] = async_i;
        for (int i = 1; i < STAGES; i++) begin
            chain_d[i] = chain_q[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain_q <= '1;
        end else begin
            chain_q <= chain_d;
        end
    end

    assign sync_o = chain_q[STAGES-1];

endmodule

// File: rtl/i2cp_cond.sv
module i2cp_cond (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_s,
    input  logic sda_s,
    output logic start_o,
    output logic stop_o,
    output logic scl_rise_o,
    output logic scl_fall_o
);

    typedef struct packed {
        logic scl;
        logic sda;
    } prev_t;

    prev_t prev_d, prev_q;

    always_comb begin
        prev_d.scl = scl_s;
        prev_d.sda = sda_s;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_q <= '1;
        end else begin
            prev_q <= prev_d;
        end
    end

    assign start_o    = scl_s & prev_q.scl & prev_q.sda & ~sda_s;
    assign stop_o     = scl_s & prev_q.scl & ~prev_q.sda & sda_s;
    assign scl_rise_o = scl_s & ~prev_q.scl;
    assign scl_fall_o = ~scl_s & prev_q.scl;

endmodule

// File: rtl/i2cp_ctrl.sv
module i2cp_ctrl
    import i2cp_pkg::*;
#(
    parameter int              NUM_REGS    = 8,
    parameter int              STRAP_W     = 3,
    parameter logic [6-STRAP_W:0] ADDR_PREFIX = 4'b0100
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       sda_s,
    input  logic                       start_i,
    input  logic                       stop_i,
    input  logic                       scl_rise_i,
    input  logic                       scl_fall_i,
    input  logic [STRAP_W-1:0]         strap_i,
    input  logic [NUM_REGS*BYTE_W-1:0] reg_data_i,
    output logic                       sda_oe_o,
    output logic [$clog2(NUM_REGS)-1:0] ptr_o,
    output logic                       in_mack_o,
    output logic                       quiet_o
);

    localparam int PTR_W  = $clog2(NUM_REGS);
    localparam int CNT_W  = $clog2(BYTE_W + 1);
    localparam logic [CNT_W-1:0] LAST_RX = CNT_W'(BYTE_W);
    localparam logic [CNT_W-1:0] LAST_TX = CNT_W'(BYTE_W - 1);
    localparam logic [PTR_W-1:0] PAIR_BIT = PTR_W'(1);

    typedef struct packed {
        bus_state_t        st;
        logic [CNT_W-1:0]  cnt;
        logic [BYTE_W-1:0] rx;
        logic [BYTE_W-1:0] tx;
        logic [PTR_W-1:0]  ptr;
        logic              rw;
        logic              mack;
        logic              oe;
    } ctrl_t;

    ctrl_t ctl_d, ctl_q;

    logic [BYTE_W-1:0] cur_byte;
    logic [BYTE_W-1:0] alt_byte;
    logic [PTR_W-1:0]  alt_ptr;
    logic              addr_hit;

    assign alt_ptr  = ctl_q.ptr ^ PAIR_BIT;
    assign cur_byte = reg_data_i[{ctl_q.ptr, 3'b000} +: BYTE_W];
    assign alt_byte = reg_data_i[{alt_ptr, 3'b000} +: BYTE_W];
    assign addr_hit = (ctl_q.rx[BYTE_W-1:1] == {ADDR_PREFIX, strap_i});

    always_comb begin
        ctl_d = ctl_q;
        if (start_i) begin
            ctl_d.st  = ST_ADDR;
            ctl_d.cnt = '0;
            ctl_d.oe  = 1'b0;
        end else if (stop_i) begin
            ctl_d.st  = ST_IDLE;
            ctl_d.cnt = '0;
            ctl_d.oe  = 1'b0;
        end else begin
            unique case (ctl_q.st)
                ST_ADDR, ST_CMD: begin
                    if (scl_rise_i && ctl_q.cnt != LAST_RX) begin
                        ctl_d.rx  = {ctl_q.rx[BYTE_W-2:0], sda_s};
                        ctl_d.cnt = ctl_q.cnt + CNT_W'(1);
                    end
                    if (scl_fall_i && ctl_q.cnt == LAST_RX) begin
                        ctl_d.cnt = '0;
                        if (ctl_q.st == ST_ADDR) begin
                            if (addr_hit) begin
                                ctl_d.oe = 1'b1;
                                ctl_d.rw = ctl_q.rx[0];
                                ctl_d.st = ST_AACK;
                            end else begin
                                ctl_d.st = ST_IDLE;
                            end
                        end else begin
                            ctl_d.ptr = ctl_q.rx[PTR_W-1:0];
                            ctl_d.oe  = 1'b1;
                            ctl_d.st  = ST_CACK;
                        end
                    end
                end
                ST_AACK: begin
                    if (scl_fall_i) begin
                        ctl_d.cnt = '0;
                        if (ctl_q.rw) begin
                            ctl_d.tx = cur_byte;
                            ctl_d.oe = ~cur_byte[BYTE_W-1];
                            ctl_d.st = ST_TX;
                        end else begin
                            ctl_d.oe = 1'b0;
                            ctl_d.st = ST_CMD;
                        end
                    end
                end
                ST_CACK: begin
                    if (scl_fall_i) begin
                        ctl_d.oe = 1'b0;
                        ctl_d.st = ST_WIGN;
                    end
                end
                ST_TX: begin
                    if (scl_fall_i) begin
                        if (ctl_q.cnt == LAST_TX) begin
                            ctl_d.oe  = 1'b0;
                            ctl_d.cnt = '0;
                            ctl_d.st  = ST_MACK;
                        end else begin
                            ctl_d.tx  = {ctl_q.tx[BYTE_W-2:0], 1'b0};
                            ctl_d.oe  = ~ctl_q.tx[BYTE_W-2];
                            ctl_d.cnt = ctl_q.cnt + CNT_W'(1);
                        end
                    end
                end
                ST_MACK: begin
                    if (scl_rise_i) begin
                        ctl_d.mack = sda_s;
                    end
                    if (scl_fall_i) begin
                        if (!ctl_q.mack) begin
                            ctl_d.ptr = alt_ptr;
                            ctl_d.tx  = alt_byte;
                            ctl_d.oe  = ~alt_byte[BYTE_W-1];
                            ctl_d.cnt = '0;
                            ctl_d.st  = ST_TX;
                        end else begin
                            ctl_d.st  = ST_IDLE;
                        end
                    end
                end
                default: begin
                    ctl_d.oe = 1'b0;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q.st   <= ST_IDLE;
            ctl_q.cnt  <= '0;
            ctl_q.rx   <= '0;
            ctl_q.tx   <= '0;
            ctl_q.ptr  <= '0;
            ctl_q.rw   <= 1'b0;
            ctl_q.mack <= 1'b1;
            ctl_q.oe   <= 1'b0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign sda_oe_o  = ctl_q.oe;
    assign ptr_o     = ctl_q.ptr;
    assign in_mack_o = (ctl_q.st == ST_MACK);
    assign quiet_o   = (ctl_q.st == ST_IDLE) || (ctl_q.st == ST_WIGN);

endmodule

// File: rtl/i2c_pair_slave.sv
module i2c_pair_slave
    import i2cp_pkg::*;
#(
    parameter int                 NUM_REGS    = 8,
    parameter int                 STRAP_W     = 3,
    parameter logic [6-STRAP_W:0] ADDR_PREFIX = 4'b0100,
    parameter int                 SYNC_STAGES = 2
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       scl_i,
    input  logic                       sda_i,
    input  logic [STRAP_W-1:0]         strap_i,
    input  logic [NUM_REGS*BYTE_W-1:0] reg_data_i,
    output logic                       sda_oe_o
);

    localparam int PTR_W = $clog2(NUM_REGS);

    logic [1:0]       line_s;
    logic             start_det;
    logic             stop_det;
    logic             scl_rise;
    logic             scl_fall;
    logic [PTR_W-1:0] rd_ptr;
    logic             in_mack;
    logic             quiet;

    i2cp_sync #(
        .WIDTH  (2),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i ({scl_i, sda_i}),
        .sync_o  (line_s)
    );

    i2cp_cond u_cond (
        .clk        (clk),
        .rst_n      (rst_n),
        .scl_s      (line_s[1]),
        .sda_s      (line_s[0]),
        .start_o    (start_det),
        .stop_o     (stop_det),
        .scl_rise_o (scl_rise),
        .scl_fall_o (scl_fall)
    );

    i2cp_ctrl #(
        .NUM_REGS    (NUM_REGS),
        .STRAP_W     (STRAP_W),
        .ADDR_PREFIX (ADDR_PREFIX)
    ) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .sda_s      (line_s[0]),
        .start_i    (start_det),
        .stop_i     (stop_det),
        .scl_rise_i (scl_rise),
        .scl_fall_i (scl_fall),
        .strap_i    (strap_i),
        .reg_data_i (reg_data_i),
        .sda_oe_o   (sda_oe_o),
        .ptr_o      (rd_ptr),
        .in_mack_o  (in_mack),
        .quiet_o    (quiet)
    );

endmodule

// File: rtl/i2cp_checker.sv
module i2cp_checker #(
    parameter int PTR_W = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic             scl_i,
    input logic             sda_oe_o,
    input logic             start_det,
    input logic             stop_det,
    input logic             in_mack,
    input logic             quiet,
    input logic [PTR_W-1:0] rd_ptr
);

    a_r10_oe_moves_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
        (sda_oe_o != $past(sda_oe_o)) |-> !scl_i);

    a_r7_stop_releases: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |=> !sda_oe_o);

    a_r8_start_releases: assert property (@(posedge clk) disable iff (!rst_n)
        start_det |=> !sda_oe_o);

    // R2, R6, R11: idle or ignoring write data means the line stays released
    a_r6_quiet_no_drive: assert property (@(posedge clk) disable iff (!rst_n)
        quiet |-> !sda_oe_o);

    a_r5_pair_toggle: assert property (@(posedge clk) disable iff (!rst_n)
        ((rd_ptr != $past(rd_ptr)) && $past(in_mack)) |->
            (rd_ptr == ($past(rd_ptr) ^ PTR_W'(1))));

endmodule

bind i2c_pair_slave i2cp_checker #(.PTR_W(PTR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_i     (scl_i),
    .sda_oe_o  (sda_oe_o),
    .start_det (start_det),
    .stop_det  (stop_det),
    .in_mack   (in_mack),
    .quiet     (quiet),
    .rd_ptr    (rd_ptr)
);

// File: tb/sim_i2c_pair_slave.sv
`timescale 1ns/1ps
module sim_i2c_pair_slave;

    localparam int H = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        scl = 1'b1;
    logic        sda_m = 1'b1;
    logic [2:0]  strap = 3'b101;
    logic [63:0] regs;
    logic        sda_oe;
    logic        sda_bus;

    int n_chk = 0;
    int n_fail = 0;
    int r10_viol = 0;
    logic mon_en = 1'b0;
    logic mon_hit = 1'b0;
    logic prev_oe = 1'b0;

    assign sda_bus = sda_m & ~sda_oe;

    always #10 clk = ~clk;

    i2c_pair_slave u0 (
        .clk        (clk),
        .rst_n      (rst_n),
        .scl_i      (scl),
        .sda_i      (sda_bus),
        .strap_i    (strap),
        .reg_data_i (regs),
        .sda_oe_o   (sda_oe)
    );

    function automatic logic [7:0] rv(input int k);
        return 8'(8'h11 * k) ^ 8'hC3;
    endfunction

    task automatic load_regs();
        for (int k = 0; k < 8; k++) regs[8*k +: 8] = rv(k);
    endtask

    always begin
        @(posedge clk);
        #1;
        if (rst_n) begin
            if (sda_oe != prev_oe && scl) r10_viol++;
            if (mon_en && sda_oe) mon_hit = 1'b1;
        end
        prev_oe = sda_oe;
    end

    task automatic chk(input logic ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic w(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; w(H); scl = 1'b1; w(H); sda_m = 1'b0; w(H); scl = 1'b0; w(4);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; w(H); scl = 1'b1; w(H); sda_m = 1'b1; w(H);
    endtask

    task automatic send_bit(input logic b);
        sda_m = b; w(H); scl = 1'b1; w(H); scl = 1'b0; w(4);
    endtask

    task automatic write_byte(input logic [7:0] b, output logic ack);
        for (int i = 7; i >= 0; i--) send_bit(b[i]);
        sda_m = 1'b1; w(H); scl = 1'b1; w(H/2); ack = sda_bus; w(H/2); scl = 1'b0; w(4);
    endtask

    task automatic read_byte(input logic mack, output logic [7:0] b);
        sda_m = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            w(H); scl = 1'b1; w(H/2); b[i] = sda_bus; w(H/2); scl = 1'b0; w(4);
        end
        sda_m = mack; w(H); scl = 1'b1; w(H); scl = 1'b0; w(4); sda_m = 1'b1;
    endtask

    function automatic logic [7:0] adr(input logic rd);
        return {4'b0100, strap, rd};
    endfunction

    task automatic set_cmd(input logic [7:0] cmd, input logic do_stop);
        logic a;
        bus_start();
        write_byte(adr(1'b0), a);
        chk(a == 1'b0, "R1 write address ack", a, 0);
        write_byte(cmd, a);
        chk(a == 1'b0, "R3 command ack", a, 0);
        if (do_stop) bus_stop();
    endtask

    task automatic t_reset();
        chk(sda_oe == 1'b0, "R12 reset sda_oe", sda_oe, 0);
    endtask

    task automatic t_read_odd();
        logic a;
        logic [7:0] b;
        set_cmd(8'h03, 1'b0);
        bus_start();
        write_byte(adr(1'b1), a);
        chk(a == 1'b0, "R1 read address ack", a, 0);
        for (int i = 0; i < 5; i++) begin
            read_byte(i == 4, b);
            if (i == 0) chk(b == rv(3), "R4 first byte from pointer", b, rv(3));
            else chk(b == rv((i % 2) ? 2 : 3), "R5 odd pair alternation", b, rv((i % 2) ? 2 : 3));
        end
        bus_stop();
    endtask

    task automatic t_read_even_nack();
        logic a;
        logic [7:0] b;
        set_cmd(8'hF4, 1'b0);
        bus_start();
        write_byte(adr(1'b1), a);
        for (int i = 0; i < 3; i++) begin
            read_byte(i == 2, b);
            chk(b == rv((i == 1) ? 5 : 4), "R5 even pair alternation", b, rv((i == 1) ? 5 : 4));
        end
        mon_hit = 1'b0; mon_en = 1'b1;
        read_byte(1'b0, b);
        chk(b == 8'hFF, "R6 no data after master NACK", b, 8'hFF);
        read_byte(1'b1, b);
        mon_en = 1'b0;
        chk(mon_hit == 1'b0, "R6 SDA released after NACK", mon_hit, 0);
        bus_stop();
    endtask

    task automatic t_mismatch();
        logic a;
        logic [7:0] b;
        bus_start();
        mon_hit = 1'b0; mon_en = 1'b1;
        write_byte({4'b0100, strap ^ 3'b001, 1'b0}, a);
        chk(a == 1'b1, "R2 strap mismatch not acked", a, 1);
        write_byte(8'h00, a);
        read_byte(1'b0, b);
        mon_en = 1'b0;
        chk(mon_hit == 1'b0, "R2 mismatch never drives", mon_hit, 0);
        bus_stop();
        bus_start();
        write_byte({4'b0110, strap, 1'b1}, a);
        chk(a == 1'b1, "R2 prefix mismatch not acked", a, 1);
        bus_stop();
    endtask

    task automatic t_stop_mid();
        logic a;
        logic [7:0] b;
        set_cmd(8'h06, 1'b1);
        bus_start();
        write_byte(adr(1'b0), a);
        for (int i = 0; i < 4; i++) send_bit(1'b1);
        bus_stop();
        w(4);
        chk(sda_oe == 1'b0, "R7 released after STOP", sda_oe, 0);
        bus_start();
        write_byte(adr(1'b1), a);
        read_byte(1'b1, b);
        chk(b == rv(6), "R7 partial command keeps pointer", b, rv(6));
        bus_stop();
    endtask

    task automatic t_restart_mid();
        logic a;
        logic [7:0] b;
        bus_start();
        send_bit(1'b0); send_bit(1'b1); send_bit(1'b1);
        set_cmd(8'h01, 1'b0);
        bus_start();
        write_byte(adr(1'b1), a);
        chk(a == 1'b0, "R8 address after repeated START", a, 0);
        read_byte(1'b1, b);
        chk(b == rv(1), "R8 R3 pointer across repeated START", b, rv(1));
        bus_stop();
    endtask

    task automatic t_write_extra();
        logic a;
        logic [7:0] b;
        set_cmd(8'h07, 1'b0);
        write_byte(8'h00, a);
        chk(a == 1'b1, "R11 extra write byte not acked", a, 1);
        bus_start();
        write_byte(adr(1'b1), a);
        read_byte(1'b0, b);
        chk(b == rv(7), "R11 pointer unchanged by data byte", b, rv(7));
        read_byte(1'b1, b);
        chk(b == rv(6), "R5 toggle from odd index 7", b, rv(6));
        bus_stop();
    endtask

    task automatic t_capture();
        logic a;
        logic [7:0] b;
        set_cmd(8'h02, 1'b0);
        bus_start();
        write_byte(adr(1'b1), a);
        w(4);
        regs[16 +: 8] = 8'h3C;
        regs[24 +: 8] = 8'h5D;
        read_byte(1'b0, b);
        chk(b == rv(2), "R9 byte captured at ack fall", b, rv(2));
        read_byte(1'b1, b);
        chk(b == 8'h5D, "R9 next byte sees new data", b, 8'h5D);
        bus_stop();
        load_regs();
    endtask

    task automatic t_strap();
        logic a;
        logic [7:0] b;
        strap = 3'b010;
        w(8);
        bus_start();
        write_byte({7'b0100101, 1'b0}, a);
        chk(a == 1'b1, "R1 old strap address refused", a, 1);
        bus_stop();
        set_cmd(8'h00, 1'b0);
        bus_start();
        write_byte(adr(1'b1), a);
        chk(a == 1'b0, "R1 new strap address acked", a, 0);
        read_byte(1'b1, b);
        chk(b == rv(0), "R4 register 0 read", b, rv(0));
        bus_stop();
    endtask

    initial begin
        load_regs();
        w(5);
        t_reset();
        rst_n = 1'b1;
        w(5);
        t_read_odd();
        t_read_even_nack();
        t_mismatch();
        t_stop_mid();
        t_restart_mid();
        t_write_extra();
        t_capture();
        t_strap();
        chk(r10_viol == 0, "R10 enable changed with SCL high", r10_viol, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule